// File: doc/BRIEF.md
# Dual Programmable PWM Clock Generator

This block derives two independent clock-enable strobes, A and B, from the master clock. PWM channel counters elsewhere on the chip use these strobes to advance. A single 32-bit mode register holds both configurations. Its low half sets up clock A and its high half sets up clock B. Each half combines an 8-bit linear divisor with a power-of-two prescale select. The resulting strobe repeats every 2^prescale × divisor master-clock cycles. Each strobe is one master-clock cycle wide.

A half that is all zero marks that clock as free, and the clock stays silent. The register is always visible on the read port. Software can therefore see which half is taken and rewrite one half while keeping the other at its current value. Rewriting a half with its current value leaves that clock running undisturbed. Writing a different value restarts that clock from the new setting.

Top module: `pwmclk_gen`

## Requirements
- R1: After reset the mode register reads zero and neither strobe pulses.
- R2: A write stores all 32 bits of `wr_data_i`, and `rd_data_o` shows the new value from the cycle after the write edge. Without a write the register holds its value.
- R3: Clock A is configured by bits 7:0 (divisor d) and bits 15:8 (prescale p). With 1 ≤ d ≤ 255 and p ≤ 10, `tick_a_o` pulses exactly every 2^p × d cycles.
- R4: Clock B is configured by bits 23:16 (divisor d) and bits 31:24 (prescale p). It follows the same period rule as R3 on `tick_b_o`.
- R5: A half that is all zero produces no strobe on its output.
- R6: A divisor field of zero silences that clock even when its prescale field is nonzero.
- R7: A prescale field above 10 silences that clock.
- R8: A write that changes a half restarts that clock. The first strobe is high in the cycle that follows the N-th rising edge after the write edge, where N = 2^p × d. The strobe is low in the cycle right after the write edge.
- R9: A write that leaves a half unchanged does not shift that clock's strobe phase.
- R10: Each strobe is high for exactly one master-clock cycle when N > 1. With N = 1 the strobe stays high every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Mode register write strobe |
| wr_data_i | input | 32 | Mode register write data |
| rd_data_o | output | 32 | Mode register contents |
| tick_a_o | output | 1 | Clock A enable strobe |
| tick_b_o | output | 1 | Clock B enable strobe |

## Verification
A write is taken at a rising edge and the register readback is due one cycle later. A changed half starts counting at the same edge, so the first strobe of that clock is due in the cycle after the N-th following edge. The bench drives inputs on falling edges and steps only through a single task that counts falling edges. Every expected strobe time is therefore an exact cycle offset from the write edge. The bench checks every cycle of a window of at least two periods against the rule "high exactly when the offset is a nonzero multiple of N". That single rule covers the period, the pulse width, restart and silence.

// File: rtl/pwmclk_pkg.sv
package pwmclk_pkg;
  localparam int HALF_W  = 16;
  localparam int DIV_W   = 8;
  localparam int PRE_W   = HALF_W - DIV_W;
  localparam int PRE_MAX = 10;
  localparam int NUM_CLK = 2;
  localparam int REG_W   = NUM_CLK * HALF_W;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [DIV_W-1:0] div;
  } clk_cfg_t;
endpackage

// File: rtl/pwmclk_regs.sv
module pwmclk_regs
  import pwmclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] mode_o,
  output clk_cfg_t         cfg_o     [NUM_CLK],
  output logic             restart_o [NUM_CLK]
);
  logic [REG_W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= '0;
    else if (wr_en_i) mode_q <= wr_data_i;
  end

  assign mode_o = mode_q;

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_half
    assign cfg_o[g] = clk_cfg_t'(mode_q[g*HALF_W +: HALF_W]);
    // only a changed half restarts its divider
    assign restart_o[g] = wr_en_i &&
        (wr_data_i[g*HALF_W +: HALF_W] != mode_q[g*HALF_W +: HALF_W]);
  end
endmodule

// File: rtl/pwmclk_div.sv
module pwmclk_div
  import pwmclk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     restart_i,
  input  clk_cfg_t cfg_i,
  output logic     tick_o
);
  localparam int PCNT_W = (PRE_MAX > 0) ? PRE_MAX : 1;

  logic [PCNT_W-1:0] pre_cnt_q, pre_lim;
  logic [DIV_W-1:0]  lin_cnt_q;
  logic              tick_q;
  logic              run, pre_wrap, lin_last;

  // mask of p ones = 2^p - 1, without a wide shifter
  always_comb begin
    pre_lim = '0;
    for (int k = 0; k < PRE_MAX; k++) pre_lim[k] = (cfg_i.pre > PRE_W'(k));
  end

  assign run      = (cfg_i.div != '0) && (cfg_i.pre <= PRE_W'(PRE_MAX));
  assign pre_wrap = (pre_cnt_q == pre_lim);
  assign lin_last = (lin_cnt_q == cfg_i.div - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q <= '0;
      lin_cnt_q <= '0;
      tick_q    <= 1'b0;
    end else if (restart_i || !run) begin
      pre_cnt_q <= '0;
      lin_cnt_q <= '0;
      tick_q    <= 1'b0;
    end else begin
      tick_q    <= pre_wrap && lin_last;
      pre_cnt_q <= pre_wrap ? '0 : pre_cnt_q + PCNT_W'(1);
      if (pre_wrap) lin_cnt_q <= lin_last ? '0 : lin_cnt_q + DIV_W'(1);
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/pwmclk_gen.sv
module pwmclk_gen
  import pwmclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             tick_a_o,
  output logic             tick_b_o
);
  clk_cfg_t           cfg     [NUM_CLK];
  logic               restart [NUM_CLK];
  logic [NUM_CLK-1:0] tick;

  pwmclk_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .mode_o    (rd_data_o),
    .cfg_o     (cfg),
    .restart_o (restart)
  );

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_div
    pwmclk_div u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart[g]),
      .cfg_i     (cfg[g]),
      .tick_o    (tick[g])
    );
  end

  assign tick_a_o = tick[0];
  assign tick_b_o = tick[1];
endmodule

// File: rtl/pwmclk_chk.sv
module pwmclk_chk
  import pwmclk_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             tick_a_o,
  input logic             tick_b_o
);
  logic a_off, b_off, a_one, b_one;
  assign a_off = (rd_data_o[7:0] == 8'd0)   || (rd_data_o[15:8]  > 8'd10);
  assign b_off = (rd_data_o[23:16] == 8'd0) || (rd_data_o[31:24] > 8'd10);
  assign a_one = (rd_data_o[15:0]  == 16'h0001);
  assign b_one = (rd_data_o[31:16] == 16'h0001);

  AST_WR_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == $past(wr_data_i));                          // R2
  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));                                    // R2
  AST_A_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_off |=> !tick_a_o);                                                // R5
  AST_B_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_off |=> !tick_b_o);                                                // R6
  AST_A_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[15:0] != rd_data_o[15:0]) |=> !tick_a_o);      // R8
  AST_B_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[31:16] != rd_data_o[31:16]) |=> !tick_b_o);    // R8
  AST_A_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_a_o && !a_one) |=> !tick_a_o);                                 // R10
  AST_B_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_b_o && !b_one) |=> !tick_b_o);                                 // R10
endmodule

bind pwmclk_gen pwmclk_chk u_chk (.*);

// File: tb/sim_pwmclk_gen.sv
`timescale 1ns/1ps
module sim_pwmclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        tick_a, tick_b;
  int n_checks = 0, n_errors = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwmclk_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .tick_a_o(tick_a), .tick_b_o(tick_b)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  function automatic int per(int p, int d);
    return (1 << p) * d;
  endfunction

  function automatic bit live(int p, int d);
    return (d != 0) && (p <= 10);
  endfunction

  // compare both strobes every cycle against the period rule
  task automatic meas(int pa, int da, int pb, int db, int win, string ra, string rb);
    int na = per(pa, da), nb = per(pb, db);
    bit ea, eb;
    int bad_a = -1, bad_b = -1, act_a = 0, act_b = 0;
    for (int t = 1; t <= win; t++) begin
      step();
      ea = live(pa, da) && (t % na == 0);
      eb = live(pb, db) && (t % nb == 0);
      if (tick_a !== ea && bad_a < 0) begin bad_a = t; act_a = tick_a; end
      if (tick_b !== eb && bad_b < 0) begin bad_b = t; act_b = tick_b; end
    end
    chk(bad_a < 0, ra, act_a, bad_a < 0 ? act_a : !act_a);
    if (bad_a >= 0) $display("  clock A p=%0d d=%0d mismatch at offset %0d", pa, da, bad_a);
    chk(bad_b < 0, rb, act_b, bad_b < 0 ? act_b : !act_b);
    if (bad_b >= 0) $display("  clock B p=%0d d=%0d mismatch at offset %0d", pb, db, bad_b);
  endtask

  task automatic run_cfg(int pa, int da, int pb, int db, string ra, string rb);
    logic [31:0] v;
    int w, na, nb;
    v = {8'(pb), 8'(db), 8'(pa), 8'(da)};
    wr(32'h0);
    wr(v);
    chk(rd_data == v, "R2", rd_data, v);
    na = live(pa, da) ? per(pa, da) : 1;
    nb = live(pb, db) ? per(pb, db) : 1;
    w = 2 * ((na > nb) ? na : nb) + 1;
    if (w < 64) w = 64;
    meas(pa, da, pb, db, w, ra, rb);
  endtask

  initial begin : main
    int t0, t;
    repeat (3) step();
    chk(rd_data == 32'h0, "R1", rd_data, 0);
    chk(tick_a == 0 && tick_b == 0, "R1", {tick_a, tick_b}, 0);
    rst_n = 1'b1;
    step();
    meas(0, 0, 0, 0, 40, "R1", "R1");

    // period sweep, both halves active together (R3 R4 R8 R10)
    for (int pa = 0; pa < 4; pa++)
      for (int da = 1; da < 7; da++)
        run_cfg(pa, da, 3 - pa, (da * 3) % 7 + 1, "R3", "R4");

    run_cfg(0, 1, 0, 1, "R10", "R10");
    run_cfg(10, 1, 0, 255, "R3", "R4");
    run_cfg(0, 0, 2, 3, "R5", "R8");
    run_cfg(2, 5, 0, 0, "R8", "R5");
    run_cfg(4, 0, 3, 0, "R6", "R6");
    run_cfg(11, 2, 200, 1, "R7", "R7");
    run_cfg(1, 3, 15, 9, "R3", "R7");

    // R9: rewriting A unchanged keeps its phase, B restarts
    wr(32'h0);
    wr(32'h0000_0105);
    t0 = cyc;
    repeat (4) step();
    wr(32'h0203_0105);
    chk(rd_data == 32'h0203_0105, "R2", rd_data, 32'h0203_0105);
    t = cyc;
    while (!tick_a && cyc < t0 + 40) step();
    chk(cyc == t0 + 10, "R9", cyc - t0, 10);
    while (!tick_b && cyc < t + 40) step();
    chk(cyc == t + 12, "R8", cyc - t, 12);

    // R9: clearing only B leaves A's cadence unbroken
    wr(32'h0);
    wr(32'h0301_0006);
    t0 = cyc;
    repeat (3) step();
    wr(32'h0000_0006);
    t = 0;
    while (cyc < t0 + 30) begin
      step();
      if (tick_a !== ((cyc - t0) % 6 == 0)) t++;
      if (tick_b) t++;
    end
    chk(t == 0, "R9", t, 0);

    done = 1;
  end

  initial begin : watchdog
    int k = 0;
    while (!done && k < 150000) begin
      @(posedge clk);
      k++;
    end
    if (!done) chk(0, "watchdog", k, 0);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule